// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block sits between two 16-bit ports, A and B. It can pass data across in either direction. The bits form two 8-bit halves, and each half has its own set of controls. A system can run the halves as two separate byte paths. It can also tie the two sets of controls together so the block acts as one 16-bit path.

Each direction of each half has a storage register, loaded by its own capture strobe. A per-direction select decides whether the far port carries the live value from the near port or the stored word.

An active-low output enable and a direction input decide which port, if either, a half drives. Tri-state pins are modelled by three signals per port:
- a sampled input value,
- an output value,
- a drive-enable bit for each half.

The registers keep capturing while the outputs are isolated. The output value always comes from a single 2:1 selection. The drive enables depend only on reset, output enable and direction. Because of this, switching a select never makes a drive enable toggle, and it never passes through a mixed value on the port.

Top module: `xcvr16_reg`

## Requirements
- R1: A rising edge on `ab_strobe[h]`, sampled on `clk`, loads half h of `a_in` into that half's A-to-B register at that clock edge.
- R2: A rising edge on `ba_strobe[h]` loads half h of `b_in` into that half's B-to-A register in the same way.
- R3: With `rst_n`=1 and `oe_n[h]`=0, `dir[h]`=1 (A to B) sets `b_drive[h]`=1 and `a_drive[h]`=0. `dir[h]`=0 (B to A) sets `a_drive[h]`=1 and `b_drive[h]`=0.
- R4: With `oe_n[h]`=1 (isolation), `a_drive[h]` and `b_drive[h]` are both 0.
- R5: Half h of `b_out` equals half h of `a_in` when `sel_ab[h]`=0 (live). It equals the A-to-B register when `sel_ab[h]`=1 (stored). This holds whatever the drive enables are.
- R6: Half h of `a_out` equals half h of `b_in` when `sel_ba[h]`=0. It equals the B-to-A register when `sel_ba[h]`=1.
- R7: Captures under R1 and R2 take place in isolation mode exactly as in transceiver mode.
- R8: In no cycle are `a_drive[h]` and `b_drive[h]` both 1.
- R9: The drive enables depend only on `rst_n`, `oe_n` and `dir`. Toggling `sel_ab` or `sel_ba` leaves them unchanged.
- R10: While `rst_n`=0 both drive enables are 0. A clock edge with `rst_n`=0 clears every register to zero.
- R11: Each half follows only its own controls. Bits [7:0] belong to half 0 and bits [15:8] to half 1.
- R12: A strobe held high for several cycles captures once, on the cycle it rose. A register is unchanged in any cycle whose strobe was low at the previous edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock that samples strobes and loads the registers |
| rst_n | input | 1 | Active-low synchronous reset |
| oe_n | input | 2 | Active-low output enable, one per half |
| dir | input | 2 | Direction per half: 1 = A to B, 0 = B to A |
| sel_ab | input | 2 | Per half: 0 = live A onto B, 1 = stored A-to-B word |
| sel_ba | input | 2 | Per half: 0 = live B onto A, 1 = stored B-to-A word |
| ab_strobe | input | 2 | Capture strobe for the A-to-B register, per half |
| ba_strobe | input | 2 | Capture strobe for the B-to-A register, per half |
| a_in | input | 16 | Value sampled from port A |
| a_out | output | 16 | Value offered to port A |
| a_drive | output | 2 | Drive enable of port A, per half |
| b_in | input | 16 | Value sampled from port B |
| b_out | output | 16 | Value offered to port B |
| b_drive | output | 2 | Drive enable of port B, per half |

## Verification
The assertions take the strobes to be synchronous to `clk`. A capture only happens if a strobe is low at one edge and high at a later edge. They also take all inputs to be steady around each rising edge.

The stimulus changes inputs only on falling edges. It returns every strobe low for a full cycle before it pulses the strobe again. The one exception is the deliberate hold test of R12.

There is no flow control at the block's edge, since the ports stand for bus pins rather than a stream. The checks therefore compare the outputs combinationally against a bench model of the two registers.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  parameter int HALF_W     = 8;
  parameter int NUM_HALVES = 2;

  typedef enum logic {
    DIR_B_TO_A = 1'b0,
    DIR_A_TO_B = 1'b1
  } xcvr_dir_e;

  typedef enum logic {
    SEL_LIVE   = 1'b0,
    SEL_STORED = 1'b1
  } xcvr_sel_e;
endpackage

// File: rtl/xcvr_strobe_reg.sv
module xcvr_strobe_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         strobe,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic strobe_q;
  logic load;

  // load only on the cycle the strobe goes from low to high
  assign load = strobe & ~strobe_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (load) q <= d;
    end
  end
endmodule

// File: rtl/xcvr_select.sv
module xcvr_select #(
  parameter int W = 8
) (
  input  logic         sel,
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  output logic [W-1:0] y
);
  import xcvr_pkg::*;

  // one 2:1 selection per bit, so the output never shows a mixed word
  always_comb begin
    if (xcvr_sel_e'(sel) == SEL_STORED) y = stored;
    else                                y = live;
  end
endmodule

// File: rtl/xcvr_drive_ctl.sv
module xcvr_drive_ctl (
  input  logic rst_n,
  input  logic oe_n,
  input  logic dir,
  output logic a_en,
  output logic b_en
);
  import xcvr_pkg::*;

  logic active;

  assign active = rst_n & ~oe_n;
  assign b_en   = active & (xcvr_dir_e'(dir) == DIR_A_TO_B);
  assign a_en   = active & (xcvr_dir_e'(dir) == DIR_B_TO_A);
endmodule

// File: rtl/xcvr_half.sv
module xcvr_half #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic         ab_strobe,
  input  logic         ba_strobe,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         a_en,
  output logic         b_en
);
  logic [W-1:0] ab_word;
  logic [W-1:0] ba_word;

  xcvr_strobe_reg #(.W(W)) u_ab_reg (
    .clk(clk), .rst_n(rst_n), .strobe(ab_strobe), .d(a_in), .q(ab_word)
  );

  xcvr_strobe_reg #(.W(W)) u_ba_reg (
    .clk(clk), .rst_n(rst_n), .strobe(ba_strobe), .d(b_in), .q(ba_word)
  );

  xcvr_select #(.W(W)) u_to_b (
    .sel(sel_ab), .live(a_in), .stored(ab_word), .y(b_out)
  );

  xcvr_select #(.W(W)) u_to_a (
    .sel(sel_ba), .live(b_in), .stored(ba_word), .y(a_out)
  );

  xcvr_drive_ctl u_drv (
    .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .a_en(a_en), .b_en(b_en)
  );
endmodule

// File: rtl/xcvr16_reg.sv
module xcvr16_reg #(
  parameter int HALF_W     = xcvr_pkg::HALF_W,
  parameter int NUM_HALVES = xcvr_pkg::NUM_HALVES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NUM_HALVES-1:0]        oe_n,
  input  logic [NUM_HALVES-1:0]        dir,
  input  logic [NUM_HALVES-1:0]        sel_ab,
  input  logic [NUM_HALVES-1:0]        sel_ba,
  input  logic [NUM_HALVES-1:0]        ab_strobe,
  input  logic [NUM_HALVES-1:0]        ba_strobe,
  input  logic [HALF_W*NUM_HALVES-1:0] a_in,
  output logic [HALF_W*NUM_HALVES-1:0] a_out,
  output logic [NUM_HALVES-1:0]        a_drive,
  input  logic [HALF_W*NUM_HALVES-1:0] b_in,
  output logic [HALF_W*NUM_HALVES-1:0] b_out,
  output logic [NUM_HALVES-1:0]        b_drive
);
  localparam int BUS_W = HALF_W * NUM_HALVES;

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_half
    xcvr_half #(.W(HALF_W)) u_half (
      .clk      (clk),
      .rst_n    (rst_n),
      .oe_n     (oe_n[h]),
      .dir      (dir[h]),
      .sel_ab   (sel_ab[h]),
      .sel_ba   (sel_ba[h]),
      .ab_strobe(ab_strobe[h]),
      .ba_strobe(ba_strobe[h]),
      .a_in     (a_in[h*HALF_W +: HALF_W]),
      .b_in     (b_in[h*HALF_W +: HALF_W]),
      .a_out    (a_out[h*HALF_W +: HALF_W]),
      .b_out    (b_out[h*HALF_W +: HALF_W]),
      .a_en     (a_drive[h]),
      .b_en     (b_drive[h])
    );
  end

  if (BUS_W < 2) begin : g_bad_width
    initial $error("bus must be at least 2 bits wide");
  end
endmodule

// File: rtl/xcvr16_reg_chk.sv
module xcvr16_reg_chk #(
  parameter int HALF_W     = 8,
  parameter int NUM_HALVES = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic [NUM_HALVES-1:0]        oe_n,
  input logic [NUM_HALVES-1:0]        dir,
  input logic [NUM_HALVES-1:0]        sel_ab,
  input logic [NUM_HALVES-1:0]        sel_ba,
  input logic [NUM_HALVES-1:0]        ab_strobe,
  input logic [NUM_HALVES-1:0]        ba_strobe,
  input logic [HALF_W*NUM_HALVES-1:0] a_in,
  input logic [HALF_W*NUM_HALVES-1:0] a_out,
  input logic [NUM_HALVES-1:0]        a_drive,
  input logic [HALF_W*NUM_HALVES-1:0] b_in,
  input logic [HALF_W*NUM_HALVES-1:0] b_out,
  input logic [NUM_HALVES-1:0]        b_drive
);
  // R10
  always @(negedge clk) begin
    if (rst_n === 1'b0) begin
      reset_quiet_chk: assert (a_drive == '0 && b_drive == '0)
        else $error("drive enable active during reset");
    end
  end

  for (genvar h = 0; h < NUM_HALVES; h++) begin : g_h
    // R8
    one_driver_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(a_drive[h] && b_drive[h]));

    // R4
    isolate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n[h] |-> (!a_drive[h] && !b_drive[h]));

    // R9
    drive_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && $stable(oe_n[h]) && $stable(dir[h]))
        |-> ($stable(a_drive[h]) && $stable(b_drive[h])));

    // R5
    live_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ab[h] |-> (b_out[h*HALF_W +: HALF_W] == a_in[h*HALF_W +: HALF_W]));

    // R6
    live_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_ba[h] |-> (a_out[h*HALF_W +: HALF_W] == b_in[h*HALF_W +: HALF_W]));

    // R12
    hold_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sel_ab[h] && $past(sel_ab[h]) && !$past(ab_strobe[h]))
        |-> $stable(b_out[h*HALF_W +: HALF_W]));

    // R12
    hold_ba_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(rst_n) && sel_ba[h] && $past(sel_ba[h]) && !$past(ba_strobe[h]))
        |-> $stable(a_out[h*HALF_W +: HALF_W]));
  end
endmodule

bind xcvr16_reg xcvr16_reg_chk #(.HALF_W(HALF_W), .NUM_HALVES(NUM_HALVES)) u_chk (
  .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
  .sel_ba(sel_ba), .ab_strobe(ab_strobe), .ba_strobe(ba_strobe),
  .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
  .b_in(b_in), .b_out(b_out), .b_drive(b_drive)
);

// File: tb/xcvr16_reg_tb.sv
module xcvr16_reg_tb;
  localparam int CLK_PERIOD = 10;
  localparam int HW = 8;
  localparam int NH = 2;
  localparam int BW = HW * NH;

  typedef struct packed {
    logic [1:0]  oe_n;
    logic [1:0]  dir;
    logic [1:0]  sab;
    logic [1:0]  sba;
    logic [1:0]  sta;
    logic [1:0]  stb;
    logic [15:0] a;
    logic [15:0] b;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{2'b00, 2'b11, 2'b00, 2'b00, 2'b00, 2'b00, 16'h1234, 16'h5678}, // live A->B
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 16'h9ABC, 16'hDEF0}, // live B->A
    '{2'b00, 2'b11, 2'b00, 2'b00, 2'b11, 2'b00, 16'hA5C3, 16'h0000}, // capture A
    '{2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 2'b00, 16'h0F0F, 16'h1111}, // stored onto B
    '{2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b11, 16'h2222, 16'h3C96}, // capture B
    '{2'b00, 2'b00, 2'b00, 2'b11, 2'b00, 2'b00, 16'h4444, 16'h7777}, // stored onto A
    '{2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 2'b11, 16'hBEEF, 16'hCAFE}, // isolate + capture both
    '{2'b11, 2'b00, 2'b11, 2'b11, 2'b00, 2'b00, 16'h0001, 16'h0002}, // isolated, stored view
    '{2'b00, 2'b01, 2'b01, 2'b10, 2'b00, 2'b00, 16'h3355, 16'h66AA}, // halves split
    '{2'b10, 2'b01, 2'b10, 2'b01, 2'b01, 2'b10, 16'h8181, 16'h7E7E}, // per-half capture
    '{2'b01, 2'b10, 2'b11, 2'b11, 2'b00, 2'b00, 16'hFFFF, 16'hFFFF}, // mixed isolate
    '{2'b00, 2'b11, 2'b10, 2'b01, 2'b00, 2'b00, 16'h00FF, 16'hFF00}  // mixed select
  };

  logic          clk = 1'b0;
  logic          rst_n;
  logic [NH-1:0] oe_n, dir, sel_ab, sel_ba, ab_strobe, ba_strobe;
  logic [BW-1:0] a_in, b_in, a_out, b_out;
  logic [NH-1:0] a_drive, b_drive;

  logic [HW-1:0] m_ab [NH];
  logic [HW-1:0] m_ba [NH];

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  xcvr16_reg u_dut (
    .clk(clk), .rst_n(rst_n), .oe_n(oe_n), .dir(dir), .sel_ab(sel_ab),
    .sel_ba(sel_ba), .ab_strobe(ab_strobe), .ba_strobe(ba_strobe),
    .a_in(a_in), .a_out(a_out), .a_drive(a_drive),
    .b_in(b_in), .b_out(b_out), .b_drive(b_drive)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    logic [NH-1:0] ea, eb;
    logic [BW-1:0] eao, ebo;
    for (int h = 0; h < NH; h++) begin
      eb[h] = rst_n & ~oe_n[h] & dir[h];
      ea[h] = rst_n & ~oe_n[h] & ~dir[h];
      ebo[h*HW +: HW] = sel_ab[h] ? m_ab[h] : a_in[h*HW +: HW];
      eao[h*HW +: HW] = sel_ba[h] ? m_ba[h] : b_in[h*HW +: HW];
    end
    check({tag, " R3/R4 a_drive"}, 32'(a_drive), 32'(ea));
    check({tag, " R3/R4 b_drive"}, 32'(b_drive), 32'(eb));
    check({tag, " R5 b_out"}, 32'(b_out), 32'(ebo));
    check({tag, " R6 a_out"}, 32'(a_out), 32'(eao));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  // R8 every cycle
  always @(negedge clk) begin
    if (rst_n === 1'b1) begin
      for (int h = 0; h < NH; h++)
        check("R8 both drivers", 32'(a_drive[h] & b_drive[h]), 32'd0);
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11; sel_ba = 2'b11;
    ab_strobe = 2'b00; ba_strobe = 2'b00;
    a_in = 16'hFFFF; b_in = 16'hFFFF;
    for (int h = 0; h < NH; h++) begin m_ab[h] = '0; m_ba[h] = '0; end
    repeat (3) @(negedge clk);
    // R10 enables held low during reset
    check("R10 a_drive in reset", 32'(a_drive), 32'd0);
    check("R10 b_drive in reset", 32'(b_drive), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 registers cleared
    check("R10 stored A->B after reset", 32'(b_out), 32'd0);
    check("R10 stored B->A after reset", 32'(a_out), 32'd0);
    check_all("reset-exit");

    // table walk: R1 R2 R7 R11
    for (int i = 0; i < NV; i++) begin
      oe_n = VECS[i].oe_n; dir = VECS[i].dir;
      sel_ab = VECS[i].sab; sel_ba = VECS[i].sba;
      ab_strobe = VECS[i].sta; ba_strobe = VECS[i].stb;
      a_in = VECS[i].a; b_in = VECS[i].b;
      @(posedge clk);
      #1;
      for (int h = 0; h < NH; h++) begin
        if (VECS[i].sta[h]) m_ab[h] = VECS[i].a[h*HW +: HW];
        if (VECS[i].stb[h]) m_ba[h] = VECS[i].b[h*HW +: HW];
      end
      @(negedge clk);
      check_all($sformatf("vec%0d R1 R2 R7 R11", i));
      ab_strobe = 2'b00; ba_strobe = 2'b00;
      @(negedge clk);
      check_all($sformatf("vec%0d settle", i));
    end

    // R12 held strobe captures only once
    oe_n = 2'b00; dir = 2'b11; sel_ab = 2'b11;
    a_in = 16'h1357; ab_strobe = 2'b11;
    @(negedge clk);
    a_in = 16'h2468;
    @(negedge clk);
    a_in = 16'h9999;
    @(negedge clk);
    check("R12 held strobe", 32'(b_out), 32'h1357);
    ab_strobe = 2'b00;
    m_ab[0] = 8'h57; m_ab[1] = 8'h13;
    @(negedge clk);
    check_all("R12 after release");

    // R9 select toggling leaves enables alone
    oe_n = 2'b00; dir = 2'b01;
    for (int k = 0; k < 4; k++) begin
      sel_ab = 2'(k); sel_ba = 2'(~k);
      #1;
      check("R9 a_drive steady", 32'(a_drive), 32'h2);
      check("R9 b_drive steady", 32'(b_drive), 32'h1);
      @(negedge clk);
    end

    // R10 synchronous clear of stored words
    sel_ab = 2'b11; sel_ba = 2'b11;
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int h = 0; h < NH; h++) begin m_ab[h] = '0; m_ba[h] = '0; end
    @(negedge clk);
    check("R10 clear b_out", 32'(b_out), 32'd0);
    check("R10 clear a_out", 32'(a_out), 32'd0);
    check_all("R10 final");

    finish_run();
  end
endmodule